// File: doc/BRIEF.md
# Register-Programmed Memory Copy Engine

This block copies a programmed number of bytes from a source address to a destination address over one memory-mapped master port. Software loads the source, the destination and the byte count through a small register port, picks a beat width and an addressing style for each side in the control register, then sets a start bit. The engine performs one read beat, waits for its data, and performs the matching write beat. It repeats this until the count is used up.

The register port covers five word-sized registers. The offsets are control 0, status 1, source 2, destination 3 and length 4. Reads are combinational. While a copy runs, writes to source, destination, length and to the control fields are ignored. Status writes and the reset bit still act during a copy. The source, destination and length registers read back their live values, so software can see how far a copy has progressed. A completion interrupt is available. A two-write software reset puts the whole engine back into its power-up state.

Top module: `mm_copy_dma`

## Requirements
- R1: After reset, the control, status, source, destination and length registers all read 0, `irq` is 0, and neither `m_rd` nor `m_wr` is asserted.
- R2: Writing control with bit 3 (start) set begins a copy only when length is nonzero. With a zero length, status bit 1 stays 0 and no bus request is made.
- R3: A read request is held, with a stable address, until `m_wait` is low at a clock edge. The matching write is issued only after `m_rvalid` returns the data, and it carries that data. The write is held, with stable address and data, until `m_wait` is low. Each beat issues exactly one accepted read and one accepted write.
- R4: With control bit 8 at 0, the source address advances by the beat width in bytes after each beat. With bit 8 at 1, every read uses the programmed source address.
- R5: With control bit 9 at 0, the destination address advances by the beat width after each beat. With bit 9 at 1, every write uses the programmed destination address.
- R6: The one-hot control bits 0, 1, 2, 10 and 11 select beats of 1, 2, 4, 8 and 16 bytes. `m_be` has exactly that many low bits set on each write. Length drops by the beat width on each accepted write and stops at 0. A remainder smaller than one beat ends the copy with a final full beat.
- R7: Status bit 1 (busy) is high from the start until the last write is accepted. Status bit 0 (done) and status bit 2 (ended on length) become 1 in the same cycle that busy falls.
- R8: `irq` is high exactly when done is 1 and control bit 4 (interrupt enable) is 1. Enabling the interrupt after completion raises it.
- R9: Any write to the status register clears done, and so drops `irq`.
- R10: Two consecutive register writes that both target control with bit 12 set put the engine into its reset state from the second clock edge after the second write. This abandons any copy in progress.
- R11: A control write with bit 12 set, followed by any other register write, leaves the reset unarmed. A later single write of bit 12 then does not reset the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_sel | input | 1 | Register port select |
| cfg_wr | input | 1 | Register write strobe (with `cfg_sel`) |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational on `cfg_addr` |
| m_addr | output | ADDR_W | Master byte address |
| m_rd | output | 1 | Master read request |
| m_wr | output | 1 | Master write request |
| m_be | output | DATA_W/8 | Write byte enables, low lanes |
| m_wdata | output | DATA_W | Write data, right-justified |
| m_rdata | input | DATA_W | Read data, right-justified |
| m_rvalid | input | 1 | Read data valid |
| m_wait | input | 1 | Slave stalls the current request |
| irq | output | 1 | Completion interrupt |

## Verification
The properties assume two things about the memory side. First, `m_rvalid` is raised once per accepted read, no earlier than the cycle after that acceptance. Second, `m_wait` only carries meaning while a request is out. The bench memory model meets both: it decides `m_wait` on the falling edge from the request it sees, and it returns read data one cycle after acceptance. It also only ever programs widths that the default build allows. Register writes are single-cycle strobes away from the clock edge, so the two-write reset and its cancellation depend only on the order of writes.

// File: rtl/mcd_pkg.sv
// Shared constants and helpers for the memory copy engine.
// Assumes a register port with 3-bit offsets and 32-bit data.
package mcd_pkg;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_SRC  = 3'd2;
    localparam logic [2:0] OFS_DST  = 3'd3;
    localparam logic [2:0] OFS_LEN  = 3'd4;

    localparam int CB_GO     = 3;
    localparam int CB_IEN    = 4;
    localparam int CB_SRCFIX = 8;
    localparam int CB_DSTFIX = 9;
    localparam int CB_SRST   = 12;

    // Control bit for each width selector, narrowest first (1,2,4,8,16 bytes)
    localparam int WSEL_POS [5] = '{0, 1, 2, 10, 11};

    localparam int SB_DONE   = 0;
    localparam int SB_BUSY   = 1;
    localparam int SB_LENEND = 2;

    typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_RWAIT, MV_WR} mv_state_e;

    // Bytes per beat from the one-hot width field; 1 if none is set
    function automatic logic [4:0] beat_bytes(input logic [4:0] sel);
        logic [4:0] n;
        n = 5'd1;
        for (int g = 0; g < 5; g++) begin
            if (sel[g]) n = 5'(1 << g);
        end
        return n;
    endfunction

endpackage

// File: rtl/mcd_sreset_seq.sv
// Two-write software reset sequencer.
// Arms on a control write with the reset bit set, fires on the very next
// register write if it is another such write, otherwise disarms.
// Firing drives the engine reset low for one cycle, then clears itself.
// Assumes: only the system reset clears this sequencer.
module mcd_sreset_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any,
    input  logic srst_hit,
    output logic eng_rst_n
);

    logic armed;
    logic fire;

    // Track the arm state and raise a one-cycle reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            fire  <= 1'b0;
        end else if (fire) begin
            armed <= 1'b0;
            fire  <= 1'b0;
        end else if (wr_any) begin
            if (srst_hit && armed) begin
                fire  <= 1'b1;
                armed <= 1'b0;
            end else begin
                armed <= srst_hit;
            end
        end
    end

    assign eng_rst_n = rst_n & ~fire;

endmodule

// File: rtl/mcd_regs.sv
// Register file of the copy engine: control, status, source, destination
// and length, plus address stepping and length countdown per beat.
// Assumes: configuration writes are ignored while busy; beat_ok only
// occurs while busy.
module mcd_regs
    import mcd_pkg::*;
#(
    parameter int         ADDR_W     = 32,
    parameter int         LEN_W      = 16,
    parameter int         CFG_W      = 32,
    parameter logic [4:0] ALLOW_MASK = 5'b11111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              busy,
    input  logic              beat_ok,
    output logic              start,
    output logic              last,
    output logic [4:0]        bytes,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              done,
    output logic              ien
);

    logic              wr_any, wr_ctl, wr_stat, wr_src, wr_dst, wr_len, cfg_ok;
    logic [4:0]        wsel;
    logic              src_fix, dst_fix, len_end, finish;
    logic [LEN_W-1:0]  len;
    logic [CFG_W-1:0]  ctl_rd;
    logic              unused_bits;

    assign wr_any  = cfg_sel & cfg_wr;
    assign wr_ctl  = wr_any && (cfg_addr == OFS_CTRL);
    assign wr_stat = wr_any && (cfg_addr == OFS_STAT);
    assign wr_src  = wr_any && (cfg_addr == OFS_SRC) && !busy;
    assign wr_dst  = wr_any && (cfg_addr == OFS_DST) && !busy;
    assign wr_len  = wr_any && (cfg_addr == OFS_LEN) && !busy;
    assign cfg_ok  = wr_ctl && !busy;
    assign unused_bits = ^cfg_wdata;

    assign start  = cfg_ok && cfg_wdata[CB_GO] && (len != '0);
    assign bytes  = beat_bytes(wsel);
    assign last   = (len <= LEN_W'(bytes));
    assign finish = beat_ok && last;

    // One storage bit per width selector that the build allows
    for (genvar g = 0; g < 5; g++) begin : g_wsel
        if (ALLOW_MASK[g]) begin : g_on
            logic bit_q;
            // Hold the selector bit written through the control register
            always_ff @(posedge clk) begin
                if (!rst_n)      bit_q <= 1'b0;
                else if (cfg_ok) bit_q <= cfg_wdata[WSEL_POS[g]];
            end
            assign wsel[g] = bit_q;
        end else begin : g_off
            assign wsel[g] = 1'b0;
        end
    end

    // Remaining control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_fix <= 1'b0;
            dst_fix <= 1'b0;
            ien     <= 1'b0;
        end else if (cfg_ok) begin
            src_fix <= cfg_wdata[CB_SRCFIX];
            dst_fix <= cfg_wdata[CB_DSTFIX];
            ien     <= cfg_wdata[CB_IEN];
        end
    end

    // Source and destination: loaded by software, stepped per beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
        end else begin
            if (wr_src)                   src_addr <= cfg_wdata[ADDR_W-1:0];
            else if (beat_ok && !src_fix) src_addr <= src_addr + ADDR_W'(bytes);
            if (wr_dst)                   dst_addr <= cfg_wdata[ADDR_W-1:0];
            else if (beat_ok && !dst_fix) dst_addr <= dst_addr + ADDR_W'(bytes);
        end
    end

    // Length countdown, floored at zero on the last beat
    always_ff @(posedge clk) begin
        if (!rst_n)        len <= '0;
        else if (wr_len)   len <= cfg_wdata[LEN_W-1:0];
        else if (beat_ok)  len <= last ? '0 : len - LEN_W'(bytes);
    end

    // Completion flags: finish sets, a status write clears done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            len_end <= 1'b0;
        end else begin
            if (finish)       done <= 1'b1;
            else if (wr_stat) done <= 1'b0;
            if (finish)       len_end <= 1'b1;
            else if (start)   len_end <= 1'b0;
        end
    end

    // Control readback image
    always_comb begin
        ctl_rd = '0;
        for (int g = 0; g < 5; g++) ctl_rd[WSEL_POS[g]] = wsel[g];
        ctl_rd[CB_IEN]    = ien;
        ctl_rd[CB_SRCFIX] = src_fix;
        ctl_rd[CB_DSTFIX] = dst_fix;
    end

    // Combinational register read mux
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFS_CTRL: cfg_rdata = ctl_rd;
            OFS_STAT: begin
                cfg_rdata[SB_DONE]   = done;
                cfg_rdata[SB_BUSY]   = busy;
                cfg_rdata[SB_LENEND] = len_end;
            end
            OFS_SRC:  cfg_rdata = CFG_W'(src_addr);
            OFS_DST:  cfg_rdata = CFG_W'(dst_addr);
            OFS_LEN:  cfg_rdata = CFG_W'(len);
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mcd_mover.sv
// Transfer loop: read request, wait for data, write request, repeat.
// Requests are held until the slave drops m_wait at a clock edge.
// Assumes: m_rvalid arrives once per accepted read, at least one cycle later.
module mcd_mover
    import mcd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                last,
    input  logic [ADDR_W-1:0]   src_addr,
    input  logic [ADDR_W-1:0]   dst_addr,
    input  logic [4:0]          bytes,
    output logic [ADDR_W-1:0]   m_addr,
    output logic                m_rd,
    output logic                m_wr,
    output logic [DATA_W/8-1:0] m_be,
    output logic [DATA_W-1:0]   m_wdata,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic                m_rvalid,
    input  logic                m_wait,
    output logic                busy,
    output logic                beat_ok
);

    localparam int BE_W = DATA_W / 8;

    mv_state_e          state;
    logic [DATA_W-1:0]  data_q;

    // Beat sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MV_IDLE;
        end else begin
            case (state)
                MV_IDLE:  if (start)    state <= MV_RD;
                MV_RD:    if (!m_wait)  state <= MV_RWAIT;
                MV_RWAIT: if (m_rvalid) state <= MV_WR;
                MV_WR:    if (!m_wait)  state <= last ? MV_IDLE : MV_RD;
                default:                state <= MV_IDLE;
            endcase
        end
    end

    // Capture read data for the matching write
    always_ff @(posedge clk) begin
        if (!rst_n)                               data_q <= '0;
        else if (state == MV_RWAIT && m_rvalid)   data_q <= m_rdata;
    end

    // Low byte lanes enabled for the current beat width
    always_comb begin
        for (int i = 0; i < BE_W; i++) m_be[i] = (i < int'(bytes));
    end

    assign m_rd    = (state == MV_RD);
    assign m_wr    = (state == MV_WR);
    assign m_addr  = (state == MV_WR) ? dst_addr : src_addr;
    assign m_wdata = data_q;
    assign busy    = (state != MV_IDLE);
    assign beat_ok = (state == MV_WR) && !m_wait;

endmodule

// File: rtl/mm_copy_dma.sv
// Top of the memory copy engine: register file, transfer loop and the
// two-write software reset sequencer. The interrupt is done gated by enable.
// Assumes ADDR_W and LEN_W do not exceed the 32-bit register width.
module mm_copy_dma
    import mcd_pkg::*;
#(
    parameter int         ADDR_W     = 32,
    parameter int         DATA_W     = 128,
    parameter int         LEN_W      = 16,
    parameter logic [4:0] ALLOW_MASK = 5'b11111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_sel,
    input  logic                cfg_wr,
    input  logic [2:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic [ADDR_W-1:0]   m_addr,
    output logic                m_rd,
    output logic                m_wr,
    output logic [DATA_W/8-1:0] m_be,
    output logic [DATA_W-1:0]   m_wdata,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic                m_rvalid,
    input  logic                m_wait,
    output logic                irq
);

    logic              eng_rst_n, wr_any, srst_hit;
    logic              busy_w, beat_ok_w, start_w, last_w, done_w, ien_w;
    logic [4:0]        bytes_w;
    logic [ADDR_W-1:0] src_w, dst_w;

    assign wr_any   = cfg_sel & cfg_wr;
    assign srst_hit = wr_any && (cfg_addr == OFS_CTRL) && cfg_wdata[CB_SRST];

    mcd_sreset_seq u_srst (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_any    (wr_any),
        .srst_hit  (srst_hit),
        .eng_rst_n (eng_rst_n)
    );

    mcd_regs #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .CFG_W      (32),
        .ALLOW_MASK (ALLOW_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (eng_rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy_w),
        .beat_ok   (beat_ok_w),
        .start     (start_w),
        .last      (last_w),
        .bytes     (bytes_w),
        .src_addr  (src_w),
        .dst_addr  (dst_w),
        .done      (done_w),
        .ien       (ien_w)
    );

    mcd_mover #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mover (
        .clk      (clk),
        .rst_n    (eng_rst_n),
        .start    (start_w),
        .last     (last_w),
        .src_addr (src_w),
        .dst_addr (dst_w),
        .bytes    (bytes_w),
        .m_addr   (m_addr),
        .m_rd     (m_rd),
        .m_wr     (m_wr),
        .m_be     (m_be),
        .m_wdata  (m_wdata),
        .m_rdata  (m_rdata),
        .m_rvalid (m_rvalid),
        .m_wait   (m_wait),
        .busy     (busy_w),
        .beat_ok  (beat_ok_w)
    );

    assign irq = done_w & ien_w;

endmodule

// File: rtl/mcd_checker.sv
// Protocol and status properties of the copy engine, bound to its top.
// Assumes the memory side follows the rules stated in the brief.
module mcd_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              eng_rst_n,
    input logic              cfg_sel,
    input logic              cfg_wr,
    input logic [2:0]        cfg_addr,
    input logic [ADDR_W-1:0] m_addr,
    input logic              m_rd,
    input logic              m_wr,
    input logic              m_wait,
    input logic [DATA_W-1:0] m_wdata,
    input logic              busy,
    input logic              done,
    input logic              ien,
    input logic              irq
);

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!eng_rst_n)
        (m_rd && m_wait) |=> (m_rd && $stable(m_addr)));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!eng_rst_n)
        (m_wr && m_wait) |=> (m_wr && $stable(m_addr) && $stable(m_wdata)));

    // R3
    one_cmd_chk: assert property (@(posedge clk) disable iff (!eng_rst_n)
        !(m_rd && m_wr));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!eng_rst_n)
        !busy |-> (!m_rd && !m_wr));

    // R7
    done_at_end_chk: assert property (@(posedge clk) disable iff (!eng_rst_n)
        ($fell(busy) && $past(eng_rst_n)) |-> done);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!eng_rst_n)
        irq |-> (done && ien));

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!eng_rst_n)
        (cfg_sel && cfg_wr && cfg_addr == 3'd1 && !busy) |=> !done);

endmodule

bind mm_copy_dma mcd_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .eng_rst_n (eng_rst_n),
    .cfg_sel   (cfg_sel),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .m_addr    (m_addr),
    .m_rd      (m_rd),
    .m_wr      (m_wr),
    .m_wait    (m_wait),
    .m_wdata   (m_wdata),
    .busy      (busy_w),
    .done      (done_w),
    .ien       (ien_w),
    .irq       (irq)
);

// File: tb/mm_copy_dma_test.sv
`timescale 1ns/1ps
// Directed bench for the copy engine with a 256-byte memory model.
module mm_copy_dma_test;

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_SRC = 3'd2, A_DST = 3'd3, A_LEN = 3'd4;
    localparam logic [31:0] C_B8 = 32'h1, C_H16 = 32'h2, C_W32 = 32'h4, C_GO = 32'h8, C_IEN = 32'h10;
    localparam logic [31:0] C_SFIX = 32'h100, C_DFIX = 32'h200, C_D64 = 32'h400, C_Q128 = 32'h800;
    localparam logic [31:0] C_SRST = 32'h1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_sel = 1'b0, cfg_wr = 1'b0;
    logic [2:0]   cfg_addr = 3'd0;
    logic [31:0]  cfg_wdata = 32'd0;
    logic [31:0]  cfg_rdata;
    logic [31:0]  m_addr;
    logic         m_rd, m_wr;
    logic [15:0]  m_be;
    logic [127:0] m_wdata;
    logic [127:0] m_rdata = '0;
    logic         m_rvalid = 1'b0;
    logic         m_wait = 1'b0;
    logic         irq;

    int n_chk = 0, n_err = 0, cyc = 0;
    logic [7:0]  mem [256];
    int          wait_n = 0, wcnt = 0, n_rd = 0, n_wr = 0;
    logic        rd_pend = 1'b0;
    logic [31:0] rd_a;
    logic [31:0] rd_log [64];
    logic [31:0] wr_log [64];
    int          be_log [64];

    mm_copy_dma uut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr), .m_be(m_be),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_rvalid(m_rvalid),
        .m_wait(m_wait), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    // Memory model: decides stalls and acceptance on the falling edge
    always @(negedge clk) begin
        m_rvalid = 1'b0;
        if (rd_pend) begin
            for (int i = 0; i < 16; i++) m_rdata[8*i +: 8] = mem[8'(rd_a + 32'(i))];
            m_rvalid = 1'b1;
            rd_pend  = 1'b0;
        end
        if (m_rd || m_wr) begin
            if (wcnt < wait_n) begin
                m_wait = 1'b1;
                wcnt++;
            end else begin
                m_wait = 1'b0;
                wcnt   = 0;
                if (m_rd) begin
                    rd_pend = 1'b1;
                    rd_a    = m_addr;
                    if (n_rd < 64) rd_log[n_rd] = m_addr;
                    n_rd++;
                end else begin
                    for (int i = 0; i < 16; i++)
                        if (m_be[i]) mem[8'(m_addr + 32'(i))] = m_wdata[8*i +: 8];
                    if (n_wr < 64) begin
                        wr_log[n_wr] = m_addr;
                        be_log[n_wr] = $countones(m_be);
                    end
                    n_wr++;
                end
            end
        end else begin
            m_wait = 1'b0;
            wcnt   = 0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_sel = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic clear_log();
        n_rd = 0;
        n_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Start a copy, poll status until busy falls, check done rises with it
    task automatic run_copy(input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] n, input logic [31:0] ctl);
        logic [31:0] st;
        int guard;
        clear_log();
        wreg(A_SRC, s);
        wreg(A_DST, d);
        wreg(A_LEN, n);
        wreg(A_CTRL, ctl | C_GO);
        guard = 0;
        do begin
            rreg(A_STAT, st);
            guard++;
        end while (st[1] && guard < 5000);
        chk("R7 done rises as busy falls", st[0], 1'b1);
        chk("R7 length-end flag at finish", st[2], 1'b1);
    endtask

    task automatic mem_cmp(input string req, input int s, input int d, input int n);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) if (mem[8'(d + i)] !== pat(s + i)) bad++;
        chk(req, bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rreg(A_CTRL, v); chk("R1 control after reset", v, 0);
        rreg(A_STAT, v); chk("R1 status after reset", v, 0);
        rreg(A_SRC, v);  chk("R1 source after reset", v, 0);
        rreg(A_LEN, v);  chk("R1 length after reset", v, 0);
        chk("R1 irq and requests idle", {irq, m_rd, m_wr}, 3'b000);
    endtask

    task automatic t_zero_len();
        logic [31:0] v;
        clear_log();
        wreg(A_LEN, 0);
        wreg(A_CTRL, C_W32 | C_GO);
        idle(3);
        rreg(A_STAT, v);
        chk("R2 zero length leaves busy low", v[1], 1'b0);
        chk("R2 zero length issues no read", n_rd, 0);
    endtask

    task automatic t_word();
        logic [31:0] v;
        run_copy(32'h10, 32'h80, 12, C_W32);
        mem_cmp("R6 word copy data", 32'h10, 32'h80, 12);
        rreg(A_SRC, v); chk("R4 source stepped by 4", v, 32'h1C);
        rreg(A_DST, v); chk("R5 destination stepped by 4", v, 32'h8C);
        rreg(A_LEN, v); chk("R6 length counted to 0", v, 0);
        chk("R6 word beat count", n_wr, 3);
        chk("R6 word byte enables", be_log[1], 4);
        chk("R3 one read per beat", n_rd, 3);
    endtask

    task automatic t_fixed_src();
        logic [31:0] v;
        int bad;
        wait_n = 2;
        run_copy(32'h40, 32'h20, 5, C_B8 | C_SFIX);
        wait_n = 0;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            if (rd_log[i] !== 32'h40) bad++;
            if (wr_log[i] !== 32'h20 + 32'(i)) bad++;
            if (mem[8'(32'h20 + i)] !== pat(32'h40)) bad++;
        end
        chk("R4 fixed source with stalls", bad, 0);
        chk("R3 stalled reads accepted once each", n_rd, 5);
        chk("R3 stalled writes accepted once each", n_wr, 5);
        rreg(A_SRC, v); chk("R4 fixed source unchanged", v, 32'h40);
    endtask

    task automatic t_fixed_dst();
        logic [31:0] v;
        int bad;
        run_copy(32'h30, 32'hA0, 6, C_H16 | C_DFIX);
        bad = 0;
        for (int i = 0; i < 3; i++) if (wr_log[i] !== 32'hA0) bad++;
        chk("R5 every write at fixed destination", bad, 0);
        chk("R5 last halfword kept", {mem[8'hA1], mem[8'hA0]}, {pat(32'h35), pat(32'h34)});
        rreg(A_DST, v); chk("R5 fixed destination unchanged", v, 32'hA0);
        rreg(A_SRC, v); chk("R4 source stepped by 2", v, 32'h36);
    endtask

    task automatic t_wide();
        logic [31:0] v;
        run_copy(32'h00, 32'hB0, 16, C_D64);
        mem_cmp("R6 doubleword data", 0, 32'hB0, 16);
        chk("R6 doubleword beats", n_wr, 2);
        chk("R6 doubleword enables", be_log[0], 8);
        run_copy(32'h50, 32'hE0, 32, C_Q128);
        mem_cmp("R6 quadword data", 32'h50, 32'hE0, 32);
        chk("R6 quadword enables", be_log[1], 16);
        chk("R5 quadword second address", wr_log[1], 32'hF0);
        run_copy(32'h60, 32'h90, 6, C_W32);
        chk("R6 remainder ends with full beat", n_wr, 2);
        rreg(A_LEN, v); chk("R6 remainder length floored", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        run_copy(32'h10, 32'h70, 1, C_B8 | C_IEN);
        #1 chk("R8 irq with enable and done", irq, 1'b1);
        wreg(A_STAT, 0);
        rreg(A_STAT, v);
        chk("R9 status write clears done", v[0], 1'b0);
        chk("R9 irq dropped", irq, 1'b0);
        run_copy(32'h10, 32'h70, 1, C_B8);
        #1 chk("R8 irq held low without enable", irq, 1'b0);
        wreg(A_CTRL, C_IEN);
        #1 chk("R8 late enable raises irq", irq, 1'b1);
        wreg(A_STAT, 32'hFFFF);
        #1 chk("R9 any status write acks irq", irq, 1'b0);
    endtask

    task automatic t_sreset();
        logic [31:0] v;
        clear_log();
        wait_n = 1000;
        wreg(A_SRC, 32'h10);
        wreg(A_DST, 32'h70);
        wreg(A_LEN, 8);
        wreg(A_CTRL, C_W32 | C_IEN | C_GO);
        idle(3);
        rreg(A_STAT, v); chk("R10 copy stalled before reset", v[1], 1'b1);
        wreg(A_CTRL, C_SRST);
        wreg(A_CTRL, C_SRST);
        idle(1);
        rreg(A_STAT, v); chk("R10 status cleared by soft reset", v, 0);
        rreg(A_CTRL, v); chk("R10 control cleared by soft reset", v, 0);
        rreg(A_LEN, v);  chk("R10 length cleared by soft reset", v, 0);
        chk("R10 read request abandoned", m_rd, 1'b0);
        wait_n = 0;
    endtask

    task automatic t_disarm();
        logic [31:0] v;
        wreg(A_SRC, 32'h5A);
        wreg(A_CTRL, C_SRST);
        wreg(A_SRC, 32'h5B);
        wreg(A_CTRL, C_SRST);
        idle(2);
        rreg(A_SRC, v); chk("R11 other write between disarms", v, 32'h5B);
        wreg(A_CTRL, 0);
        wreg(A_CTRL, C_SRST);
        idle(2);
        rreg(A_SRC, v); chk("R11 control write without bit disarms", v, 32'h5B);
        wreg(A_CTRL, C_SRST);
        idle(1);
        rreg(A_SRC, v); chk("R10 back-to-back pair resets", v, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero_len();
        t_word();
        t_fixed_src();
        t_fixed_dst();
        t_wide();
        t_irq();
        t_sreset();
        t_disarm();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule